// File: doc/BRIEF.md
# Serial Line Wake and Baud Measurement Controller

This block sits on the receive side of an asynchronous serial port. Software can arm a wake mode. In that mode the controller waits on the receive line for a long low period (a Break) and then for the line to return high. When that happens it raises a one-cycle wake pulse and disarms the wake mode by itself.

Software can also arm a baud measurement. The controller then times a 0x55 Sync character and writes the result into a divisor register. While the measurement runs it holds the transmitter off. Arming both modes together gives the usual sequence: the port sleeps, wakes on a Break, and then measures the Sync that follows.

The transmitter data path, the transmit queue and the receive shifter sit outside this block. It reaches them only through a hold output and a queue-flush pulse.

Top module: `abw_autobaud`

## Requirements
- R1: After reset the divisor reads DIV_RST (default 4). The completion flag, the wake and measurement enables, the wake pulse, the hold and the flush outputs are all low.
- R2: While wake mode is armed, a receive line low for L cycles and then high raises `wake_o` for one cycle if L >= (10 * divisor * 2^OVS_LOG2) / 8. With the defaults this is 10 * divisor cycles: 40 at divisor 4 and 60 at divisor 6. A shorter low period is ignored and wake mode stays armed.
- R3: Wake mode disarms itself at the same clock edge that raises `wake_o`.
- R4: A measurement runs only while the measurement enable is set and wake mode is clear. It counts the clock cycles from the first rising edge of the line to the fifth rising edge; for 0x55 sent LSB first with a start bit, that is 8 bit times. The count starts from zero, and at the fifth rising edge the divisor becomes count >> OVS_LOG2. A Sync of P cycles per bit therefore yields a divisor of exactly P.
- R5: At the edge where the divisor is loaded, the completion flag sets, the measurement enable clears itself and the hold drops.
- R6: `tx_hold_o` is high exactly while the measurement enable is set.
- R7: When a measurement ends, by completion or by abort, `txq_flush_o` pulses for one cycle if transmit enable was high at the cycle the measurement was armed, and stays low otherwise.
- R8: A clear-measurement strobe aborts a measurement that sees no edges. The controller returns to idle, the divisor is unchanged and the flag does not set. A later measurement starts again from the first edge.
- R9: Port enable low or receive enable low clears wake mode, the measurement enable, the flag and all edge-count and timing state, and keeps the divisor. Once re-enabled, a new measurement behaves as if fresh.
- R10: A flag-acknowledge strobe clears the completion flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial receive line, idles high |
| port_en_i | input | 1 | Port enable; low resets the controller state |
| rx_en_i | input | 1 | Receive enable; low resets the controller state |
| tx_en_i | input | 1 | Transmit enable, sampled when a measurement is armed |
| wue_set_i | input | 1 | Strobe: arm wake mode |
| abd_set_i | input | 1 | Strobe: arm baud measurement |
| abd_clr_i | input | 1 | Strobe: abort/clear baud measurement |
| flag_ack_i | input | 1 | Strobe: clear completion flag |
| div_o | output | DIV_W | Divisor register read value |
| flag_o | output | 1 | Measurement-complete flag |
| wue_o | output | 1 | Wake mode armed |
| abd_o | output | 1 | Measurement armed |
| wake_o | output | 1 | One-cycle pulse on Break wake |
| tx_hold_o | output | 1 | Hold the transmitter |
| txq_flush_o | output | 1 | One-cycle pulse: discard queued transmit character |

## Verification
The bench tests Break detection with low periods one cycle short of the threshold and exactly at it. It does this at two divisor values, which shows that the threshold follows the measured divisor. Sync characters at 6, 13, 5 and 7 cycles per bit must give back those exact divisors, so any constant offset in the count shows up. A wake followed directly by a Sync checks the combined sequence. A silent measurement that is then aborted checks the way out. A Sync cut off by a port disable must leave no edges behind: the next full Sync would finish early if state survived. Flush counts with transmit enable high and low separate the two queue outcomes.

// File: rtl/abw_pkg.sv
package abw_pkg;

  typedef enum logic {
    MT_ARMED = 1'b0,
    MT_COUNT = 1'b1
  } meter_st_e;

  // Low cycles that qualify as a Break: ten bit times, where one bit time
  // is div * 2^sh / 8 clock cycles.
  function automatic logic [31:0] brk_limit(input logic [31:0] div, input int unsigned sh);
    logic [31:0] t;
    t = div * 32'd10;
    return (t << sh) >> 3;
  endfunction

  // Divisor from the cycle count over eight bit times.
  function automatic logic [31:0] div_from_count(input logic [31:0] cnt, input int unsigned sh);
    return cnt >> sh;
  endfunction

endpackage

// File: rtl/abw_rx_edge.sv
module abw_rx_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  output logic line_o,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] stg;
  logic                   prev_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[0] <= 1'b1;
        else        stg[0] <= rx_i;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[g] <= 1'b1;
        else        stg[g] <= stg[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= stg[SYNC_STAGES-1];

  assign line_o = stg[SYNC_STAGES-1];
  assign rise_o = line_o & ~prev_q;
endmodule

// File: rtl/abw_break_det.sv
module abw_break_det #(
  parameter int CW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          line_i,
  input  logic          rise_i,
  input  logic [CW-1:0] limit_i,
  output logic          hit_o
);
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  low_cnt <= '0;
    else if (!en_i || line_i)    low_cnt <= '0;
    else if (low_cnt != '1)      low_cnt <= low_cnt + 1'b1;

  // On the rising edge cycle low_cnt still holds the length of the low period.
  assign hit_o = en_i & rise_i & (low_cnt >= limit_i);
endmodule

// File: rtl/abw_baud_meter.sv
module abw_baud_meter #(
  parameter int CNT_W = 19,
  parameter int EDGES = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             rise_i,
  output logic             done_o,
  output logic [CNT_W-1:0] count_o
);
  import abw_pkg::*;

  localparam int ECW = $clog2(EDGES + 1);
  localparam logic [ECW-1:0] LAST = ECW'(EDGES - 1);

  meter_st_e        st;
  logic [CNT_W-1:0] cnt;
  logic [ECW-1:0]   ecnt;
  logic             last_edge;

  assign last_edge = (st == MT_COUNT) & rise_i & (ecnt == LAST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st   <= MT_ARMED;
      cnt  <= '0;
      ecnt <= '0;
    end else if (!en_i) begin
      st   <= MT_ARMED;
      cnt  <= '0;
      ecnt <= '0;
    end else begin
      case (st)
        MT_ARMED: if (rise_i) begin
          st   <= MT_COUNT;
          cnt  <= '0;
          ecnt <= ECW'(1);
        end
        MT_COUNT: begin
          if (cnt != '1) cnt <= cnt + 1'b1;
          if (rise_i) begin
            if (last_edge) begin
              st   <= MT_ARMED;
              ecnt <= '0;
            end else begin
              ecnt <= ecnt + 1'b1;
            end
          end
        end
        default: st <= MT_ARMED;
      endcase
    end

  assign done_o  = en_i & last_edge;
  assign count_o = (cnt == '1) ? cnt : cnt + 1'b1;
endmodule

// File: rtl/abw_autobaud.sv
module abw_autobaud #(
  parameter int DIV_W       = 16,
  parameter int OVS_LOG2    = 3,
  parameter int DIV_RST     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic             port_en_i,
  input  logic             rx_en_i,
  input  logic             tx_en_i,
  input  logic             wue_set_i,
  input  logic             abd_set_i,
  input  logic             abd_clr_i,
  input  logic             flag_ack_i,
  output logic [DIV_W-1:0] div_o,
  output logic             flag_o,
  output logic             wue_o,
  output logic             abd_o,
  output logic             wake_o,
  output logic             tx_hold_o,
  output logic             txq_flush_o
);
  import abw_pkg::*;

  localparam int CNT_W = DIV_W + OVS_LOG2;
  localparam int LIM_W = DIV_W + OVS_LOG2 + 2;

  logic             run, line, rise;
  logic             brk_en, meter_en, brk_hit, meas_done, abd_end;
  logic [LIM_W-1:0] limit;
  logic [CNT_W-1:0] meas_cnt;
  logic [DIV_W-1:0] new_div;

  logic [DIV_W-1:0] div_q;
  logic             wue_q, abd_q, flag_q, tx_was_q, wake_q, flush_q;

  assign run      = port_en_i & rx_en_i;
  assign brk_en   = run & wue_q;
  assign meter_en = run & abd_q & ~wue_q & ~abd_set_i;
  assign abd_end  = abd_q & (meas_done | abd_clr_i);
  assign limit    = LIM_W'(brk_limit(32'(div_q), OVS_LOG2));
  assign new_div  = DIV_W'(div_from_count(32'(meas_cnt), OVS_LOG2));

  abw_rx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .line_o(line), .rise_o(rise)
  );

  abw_break_det #(.CW(LIM_W)) u_brk (
    .clk(clk), .rst_n(rst_n), .en_i(brk_en), .line_i(line), .rise_i(rise),
    .limit_i(limit), .hit_o(brk_hit)
  );

  abw_baud_meter #(.CNT_W(CNT_W), .EDGES(5)) u_meter (
    .clk(clk), .rst_n(rst_n), .en_i(meter_en), .rise_i(rise),
    .done_o(meas_done), .count_o(meas_cnt)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_q    <= DIV_W'(DIV_RST);
      wue_q    <= 1'b0;
      abd_q    <= 1'b0;
      flag_q   <= 1'b0;
      tx_was_q <= 1'b0;
      wake_q   <= 1'b0;
      flush_q  <= 1'b0;
    end else if (!run) begin
      wue_q    <= 1'b0;
      abd_q    <= 1'b0;
      flag_q   <= 1'b0;
      tx_was_q <= 1'b0;
      wake_q   <= 1'b0;
      flush_q  <= 1'b0;
    end else begin
      wake_q  <= brk_hit;
      flush_q <= abd_end & tx_was_q;

      if (brk_hit)        wue_q <= 1'b0;
      else if (wue_set_i) wue_q <= 1'b1;

      if (abd_clr_i || meas_done) begin
        abd_q    <= 1'b0;
        tx_was_q <= 1'b0;
      end else if (abd_set_i) begin
        abd_q    <= 1'b1;
        tx_was_q <= tx_en_i;
      end

      if (meas_done) div_q <= new_div;

      if (meas_done)       flag_q <= 1'b1;
      else if (flag_ack_i) flag_q <= 1'b0;
    end

  assign div_o       = div_q;
  assign flag_o      = flag_q;
  assign wue_o       = wue_q;
  assign abd_o       = abd_q;
  assign wake_o      = wake_q;
  assign tx_hold_o   = abd_q;
  assign txq_flush_o = flush_q;
endmodule

// File: rtl/abw_autobaud_chk.sv
module abw_autobaud_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             port_en_i,
  input logic             rx_en_i,
  input logic [DIV_W-1:0] div_o,
  input logic             flag_o,
  input logic             wue_o,
  input logic             abd_o,
  input logic             wake_o,
  input logic             tx_hold_o,
  input logic             txq_flush_o,
  input logic             brk_hit,
  input logic             meas_done
);
  // R2
  wake_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_hit |=> wake_o);

  // R3
  wue_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (!wue_o && $past(wue_o)));

  // R4
  div_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_o) |-> $past(meas_done));

  // R5
  done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meas_done |=> (flag_o && !abd_o && !tx_hold_o));

  // R7
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txq_flush_o |-> ($past(abd_o) && !abd_o));

  // R9
  disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(port_en_i && rx_en_i) |=> (!wue_o && !abd_o && !flag_o && !tx_hold_o));
endmodule

bind abw_autobaud abw_autobaud_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .port_en_i(port_en_i), .rx_en_i(rx_en_i),
  .div_o(div_o), .flag_o(flag_o), .wue_o(wue_o), .abd_o(abd_o),
  .wake_o(wake_o), .tx_hold_o(tx_hold_o), .txq_flush_o(txq_flush_o),
  .brk_hit(brk_hit), .meas_done(meas_done)
);

// File: tb/tb_abw_autobaud.sv
module tb_abw_autobaud;
  localparam int CLK_P   = 10;
  localparam int DIV_W   = 16;
  localparam int DIV_RST = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1;
  logic port_en = 1'b1, rx_en = 1'b1, tx_en = 1'b0;
  logic wue_set = 1'b0, abd_set = 1'b0, abd_clr = 1'b0, flag_ack = 1'b0;
  logic [DIV_W-1:0] div_o;
  logic flag_o, wue_o, abd_o, wake_o, tx_hold_o, txq_flush_o;

  int total = 0, bad = 0;
  int wake_cnt = 0, flush_cnt = 0;
  logic flag_prev = 1'b0;
  logic [DIV_W-1:0] exp_q[$];
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  abw_autobaud #(.DIV_W(DIV_W), .OVS_LOG2(3), .DIV_RST(DIV_RST), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .port_en_i(port_en), .rx_en_i(rx_en),
    .tx_en_i(tx_en), .wue_set_i(wue_set), .abd_set_i(abd_set), .abd_clr_i(abd_clr),
    .flag_ack_i(flag_ack), .div_o(div_o), .flag_o(flag_o), .wue_o(wue_o),
    .abd_o(abd_o), .wake_o(wake_o), .tx_hold_o(tx_hold_o), .txq_flush_o(txq_flush_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // 0 wake arm, 1 measure arm, 2 measure clear, 3 flag ack, 4 wake+measure arm
  task automatic strobe(input int which);
    case (which)
      0: wue_set = 1'b1;
      1: abd_set = 1'b1;
      2: abd_clr = 1'b1;
      3: flag_ack = 1'b1;
      default: begin wue_set = 1'b1; abd_set = 1'b1; end
    endcase
    @(negedge clk);
    wue_set = 1'b0; abd_set = 1'b0; abd_clr = 1'b0; flag_ack = 1'b0;
  endtask

  task automatic send_low(input int n);
    rx = 1'b0;
    repeat (n) @(negedge clk);
    rx = 1'b1;
  endtask

  task automatic drive_bit(input logic v, input int p);
    rx = v;
    repeat (p) @(negedge clk);
  endtask

  // Start bit, 0x55 LSB first, stop bit; nbits limits how many are sent.
  task automatic send_sync(input int p, input int nbits, input bit expect_done);
    logic [9:0] frame;
    frame = {1'b1, 8'h55, 1'b0};
    if (expect_done) exp_q.push_back(DIV_W'(p));
    for (int i = 0; i < nbits; i++) drive_bit(frame[i], p);
    rx = 1'b1;
  endtask

  // Scoreboard monitor: pops the expected divisor on each completion.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (wake_o) wake_cnt++;
      if (txq_flush_o) flush_cnt++;
      if (flag_o && !flag_prev) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected completion", int'(div_o), -1);
        end else begin
          logic [DIV_W-1:0] e;
          e = exp_q.pop_front();
          check(div_o == e, "R4 divisor", int'(div_o), int'(e));
          check(!abd_o && !tx_hold_o, "R5 enable/hold drop", int'({abd_o, tx_hold_o}), 0);
        end
      end
      flag_prev <= flag_o;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check(div_o == DIV_W'(DIV_RST), "R1 divisor", int'(div_o), DIV_RST);
    check({flag_o, wue_o, abd_o, wake_o, tx_hold_o, txq_flush_o} == 6'b0, "R1 outputs",
          int'({flag_o, wue_o, abd_o, wake_o, tx_hold_o, txq_flush_o}), 0);

    // R2 boundary at divisor 4 (limit 40)
    strobe(0);
    idle(3);
    send_low(39);
    idle(6);
    check(wue_o == 1'b1 && wake_cnt == 0, "R2 short low ignored", wake_cnt, 0);
    send_low(40);
    idle(6);
    check(wake_cnt == 1, "R2 break wakes", wake_cnt, 1);
    check(wue_o == 1'b0, "R3 wake mode self-clears", int'(wue_o), 0);

    // Combined wake + measurement, transmit enabled at arm time
    tx_en = 1'b1;
    strobe(4);
    idle(3);
    check(tx_hold_o && abd_o, "R6 hold while armed", int'(tx_hold_o), 1);
    send_low(40);
    idle(6);
    check(wake_cnt == 2 && !wue_o && abd_o, "R4 wake then measure", wake_cnt, 2);
    send_sync(6, 10, 1);
    idle(10);
    check(exp_q.size() == 0, "R4 combined sync done", exp_q.size(), 0);
    check(flush_cnt == 1, "R7 flush when tx was enabled", flush_cnt, 1);
    check(flag_o == 1'b1, "R5 flag set", int'(flag_o), 1);
    strobe(3);
    idle(1);
    check(flag_o == 1'b0, "R10 flag ack", int'(flag_o), 0);

    // R2 at new divisor 6 (limit 60)
    tx_en = 1'b0;
    strobe(0);
    idle(3);
    send_low(59);
    idle(6);
    check(wake_cnt == 2 && wue_o, "R2 short low at div 6", wake_cnt, 2);
    send_low(60);
    idle(6);
    check(wake_cnt == 3 && !wue_o, "R2 break at div 6", wake_cnt, 3);

    // Stand-alone measurement, transmit disabled
    strobe(1);
    idle(3);
    send_sync(13, 10, 1);
    idle(10);
    check(exp_q.size() == 0, "R4 stand-alone sync", exp_q.size(), 0);
    check(flush_cnt == 1, "R7 no flush when tx was off", flush_cnt, 1);
    strobe(3);

    // R8 abort with a silent line
    strobe(1);
    idle(300);
    check(abd_o && tx_hold_o, "R6 hold while waiting for edges", int'(tx_hold_o), 1);
    strobe(2);
    idle(2);
    check(!abd_o && !tx_hold_o, "R8 abort to idle", int'({abd_o, tx_hold_o}), 0);
    check(div_o == 16'd13 && !flag_o, "R8 divisor kept, no flag", int'(div_o), 13);
    strobe(1);
    idle(3);
    send_sync(5, 10, 1);
    idle(10);
    check(exp_q.size() == 0, "R8 measurement after abort", exp_q.size(), 0);
    strobe(3);

    // R9 port disable in mid-Sync
    tx_en = 1'b1;
    strobe(1);
    idle(3);
    send_sync(8, 4, 0);
    port_en = 1'b0;
    idle(3);
    check(!abd_o && !tx_hold_o && !flag_o, "R9 disable clears state",
          int'({abd_o, tx_hold_o, flag_o}), 0);
    check(div_o == 16'd5, "R9 divisor kept", int'(div_o), 5);
    port_en = 1'b1;
    tx_en = 1'b0;
    idle(3);
    strobe(1);
    idle(3);
    send_sync(7, 10, 1);
    idle(10);
    check(exp_q.size() == 0 && div_o == 16'd7, "R9 fresh measurement", int'(div_o), 7);
    check(flush_cnt == 1, "R9 no flush on disable", flush_cnt, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule